// File: doc/BRIEF.md
# Kernel Control Register Slave

This block is a small AXI4-Lite register file that sits between a host processor and a streaming image-processing kernel. Software programs the frame size (active pixels per line and active lines per frame) and a two-bit colour-filter grid phase. It launches the kernel by setting a start bit, and it follows progress through the kernel's done, idle and ready indications. The configuration values drive the kernel directly, and the start bit is the kernel's start input.

Several bits carry their own access rules. The start bit is set by software and drops by itself once the kernel takes the start (ready high while start is high). The done bit latches a kernel completion and clears when software reads the control word. An auto-restart bit re-arms start on every completion. Two interrupt status bits latch rising edges of done and ready, and a write of 1 flips them. A single level interrupt output combines status, per-source enables and a global enable.

Each AXI channel carries one transaction at a time. A write is taken only when address and data are presented together. Accesses to offsets with no register complete normally, return zero and change nothing.

Top module: `kernel_ctl_slave`

## Requirements
- R1: After reset `kStart`, `irq`, `cfgWidth`, `cfgHeight` and `cfgPhase` are 0, and every register reads 0 apart from the live idle and ready bits.
- R2: Registers sit at byte offsets control 0x00, global enable 0x04, source enables 0x08, status 0x0C, width 0x10, height 0x18 and phase 0x28, and address bits 1:0 are ignored. Global enable keeps bit 0, source enables keep bits 1:0 and phase keeps bits 1:0. All other bits read 0. Width and height drive `cfgWidth`/`cfgHeight` and phase drives `cfgPhase`.
- R3: Writing control with bit 0 = 1 (byte lane 0 enabled) sets `kStart` one cycle after the write is accepted. Writing bit 0 = 0 does not clear it. `kStart` falls in the cycle after a clock edge at which `kReady` is high while `kStart` is high.
- R4: Control bit 1 (done) becomes 1 after any edge where `kDone` is high. Writes do not change it. A read of the control word returns it and clears it, unless `kDone` is high at that same edge.
- R5: Control bit 2 returns `kIdle` and bit 3 returns `kReady`, both as sampled at the edge that accepts the read.
- R6: Control bit 7 is a read/write auto-restart enable. While it is 1, an edge with `kDone` high sets `kStart`.
- R7: Status bit 0 sets on a rising edge of `kDone` and bit 1 on a rising edge of `kReady`. Writing 1 to a status bit flips it, and a rising edge at the same edge wins over the flip.
- R8: `irq` is global enable bit 0 AND the OR, over both sources, of status bit AND source enable bit (bit 0 done, bit 1 ready).
- R9: Width and height are 16 bits and honour byte strobes: `wstrb[0]` updates bits 7:0 and `wstrb[1]` updates bits 15:8. Every other register updates only when `wstrb[0]` is set.
- R10: Writes to unmapped offsets change no register. Reads of them return 0. `bresp` and `rresp` are always OKAY (0).
- R11: `awready` and `wready` are high only when `awvalid` and `wvalid` are both high and no write response is pending. `arready` is high only when `arvalid` is high and no read response is pending. `bvalid` holds until `bready`, and `rvalid` and `rdata` hold until `rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response taken |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address accepted |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data taken |
| kStart | output | 1 | Start request to the kernel |
| kDone | input | 1 | Kernel completion indication |
| kIdle | input | 1 | Kernel idle indication |
| kReady | input | 1 | Kernel accepts start / new input |
| cfgWidth | output | DIM_W | Active pixels per line |
| cfgHeight | output | DIM_W | Active lines per frame |
| cfgPhase | output | 2 | Colour-filter grid start phase |
| irq | output | 1 | Level interrupt |

## Verification
Most of the state drives a port directly. A wrong start bit, configuration value or interrupt term shows on `kStart`, `cfg*` or `irq` in the first cycle after the edge that went wrong. A bad done latch, status latch or read decode shows only when software reads the register, so it appears on `rdata` one cycle after the read is accepted. A stale done bit therefore persists until the next read of the control word. A response-channel fault shows on `bvalid`/`rvalid` or the ready outputs in the same or the next cycle.

// File: rtl/kctl_pkg.sv
package kctl_pkg;

  typedef enum logic [2:0] {
    SEL_CTL, SEL_GIE, SEL_IER, SEL_ISR, SEL_WIDTH, SEL_HEIGHT, SEL_PHASE, SEL_NONE
  } regSel_e;

  // Strobes from the bus control to the register datapath.
  typedef struct packed {
    logic    wrEn;
    regSel_e wrSel;
    logic    rdEn;
    regSel_e rdSel;
  } kctlStrobe_t;

  // Byte offsets; address bits 1:0 are ignored.
  function automatic regSel_e decodeOff(input logic [31:0] off);
    case (off & 32'hFFFF_FFFC)
      32'h00:  return SEL_CTL;
      32'h04:  return SEL_GIE;
      32'h08:  return SEL_IER;
      32'h0C:  return SEL_ISR;
      32'h10:  return SEL_WIDTH;
      32'h18:  return SEL_HEIGHT;
      32'h28:  return SEL_PHASE;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/kctl_bus.sv
module kctl_bus
  import kctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [DATA_W-1:0] rdValue,
  output kctlStrobe_t       st
);

  logic wrTake;
  logic rdTake;

  assign wrTake  = awvalid && wvalid && !bvalid;
  assign rdTake  = arvalid && !rvalid;
  assign awready = wrTake;
  assign wready  = wrTake;
  assign arready = rdTake;
  assign bresp   = 2'b00;
  assign rresp   = 2'b00;

  always_comb begin
    st.wrEn  = wrTake;
    st.wrSel = decodeOff(32'(awaddr));
    st.rdEn  = rdTake;
    st.rdSel = decodeOff(32'(araddr));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bvalid <= 1'b0;
    end else if (wrTake) begin
      bvalid <= 1'b1;
    end else if (bready) begin
      bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rdTake) begin
      rvalid <= 1'b1;
      rdata  <= rdValue;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end

  // R11
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    bvalid && !bready |=> bvalid);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rvalid && !rready |=> rvalid && $stable(rdata));

endmodule

// File: rtl/kctl_regs.sv
module kctl_regs
  import kctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  kctlStrobe_t       st,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic [DATA_W-1:0] rdValue,
  output logic              kStart,
  input  logic              kDone,
  input  logic              kIdle,
  input  logic              kReady,
  output logic [DIM_W-1:0]  cfgWidth,
  output logic [DIM_W-1:0]  cfgHeight,
  output logic [1:0]        cfgPhase,
  output logic              irq
);

  // DIM_W must be a multiple of 8 and no larger than DATA_W.
  localparam int DIM_BYTES = DIM_W / 8;

  logic       startBit, doneBit, autoBit, gieBit;
  logic [1:0] ierBits, isrBits, phaseBits;
  logic [DIM_W-1:0] widthReg, heightReg;
  logic       prevDone, prevReady;

  logic wrCtl, wrGie, wrIer, wrIsr, wrWidth, wrHeight, wrPhase, rdCtl;
  logic startSet;
  logic [1:0] isrRise, isrFlip;
  logic unusedBits;

  assign wrCtl    = st.wrEn && (st.wrSel == SEL_CTL);
  assign wrGie    = st.wrEn && (st.wrSel == SEL_GIE);
  assign wrIer    = st.wrEn && (st.wrSel == SEL_IER);
  assign wrIsr    = st.wrEn && (st.wrSel == SEL_ISR);
  assign wrWidth  = st.wrEn && (st.wrSel == SEL_WIDTH);
  assign wrHeight = st.wrEn && (st.wrSel == SEL_HEIGHT);
  assign wrPhase  = st.wrEn && (st.wrSel == SEL_PHASE);
  assign rdCtl    = st.rdEn && (st.rdSel == SEL_CTL);

  assign startSet = (wrCtl && wstrb[0] && wdata[0]) || (autoBit && kDone);
  assign isrRise  = {kReady && !prevReady, kDone && !prevDone};
  assign isrFlip  = (wrIsr && wstrb[0]) ? wdata[1:0] : 2'b00;

  assign unusedBits = ^{wdata[DATA_W-1:DIM_W], wstrb[DATA_W/8-1:DIM_BYTES]};

  // Handshake and event state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit  <= 1'b0;
      doneBit   <= 1'b0;
      isrBits   <= 2'b00;
      prevDone  <= 1'b0;
      prevReady <= 1'b0;
    end else begin
      if (startSet)                startBit <= 1'b1;
      else if (startBit && kReady) startBit <= 1'b0;

      if (kDone)      doneBit <= 1'b1;
      else if (rdCtl) doneBit <= 1'b0;

      isrBits   <= (isrBits ^ isrFlip) | isrRise;
      prevDone  <= kDone;
      prevReady <= kReady;
    end
  end

  // Plain configuration state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoBit   <= 1'b0;
      gieBit    <= 1'b0;
      ierBits   <= 2'b00;
      phaseBits <= 2'b00;
      widthReg  <= '0;
      heightReg <= '0;
    end else begin
      if (wrCtl && wstrb[0])   autoBit   <= wdata[7];
      if (wrGie && wstrb[0])   gieBit    <= wdata[0];
      if (wrIer && wstrb[0])   ierBits   <= wdata[1:0];
      if (wrPhase && wstrb[0]) phaseBits <= wdata[1:0];
      for (int b = 0; b < DIM_BYTES; b++) begin
        if (wrWidth && wstrb[b])  widthReg[b*8 +: 8]  <= wdata[b*8 +: 8];
        if (wrHeight && wstrb[b]) heightReg[b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  always_comb begin
    rdValue = '0;
    case (st.rdSel)
      SEL_CTL: begin
        rdValue[0] = startBit;
        rdValue[1] = doneBit;
        rdValue[2] = kIdle;
        rdValue[3] = kReady;
        rdValue[7] = autoBit;
      end
      SEL_GIE:    rdValue[0]       = gieBit;
      SEL_IER:    rdValue[1:0]     = ierBits;
      SEL_ISR:    rdValue[1:0]     = isrBits;
      SEL_WIDTH:  rdValue[DIM_W-1:0] = widthReg;
      SEL_HEIGHT: rdValue[DIM_W-1:0] = heightReg;
      SEL_PHASE:  rdValue[1:0]     = phaseBits;
      default:    rdValue          = '0;
    endcase
  end

  assign kStart    = startBit;
  assign cfgWidth  = widthReg;
  assign cfgHeight = heightReg;
  assign cfgPhase  = phaseBits;
  assign irq       = gieBit && |(isrBits & ierBits);

  // R3
  start_handshake_chk: assert property (@(posedge clk) disable iff (!rstN)
    kStart && kReady && !kDone && !st.wrEn |=> !kStart);

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdCtl && !kDone |=> !doneBit);

  // R6
  auto_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoBit && kDone |=> kStart);

  // R7
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kReady) |=> isrBits[1]);

  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(kDone) && gieBit && ierBits[0] && !st.wrEn |=> irq);

endmodule

// File: rtl/kernel_ctl_slave.sv
module kernel_ctl_slave
  import kctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic                arvalid,
  output logic                arready,
  output logic [DATA_W-1:0]   rdata,
  output logic [1:0]          rresp,
  output logic                rvalid,
  input  logic                rready,
  output logic                kStart,
  input  logic                kDone,
  input  logic                kIdle,
  input  logic                kReady,
  output logic [DIM_W-1:0]    cfgWidth,
  output logic [DIM_W-1:0]    cfgHeight,
  output logic [1:0]          cfgPhase,
  output logic                irq
);

  kctlStrobe_t       st;
  logic [DATA_W-1:0] rdValue;

  kctl_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uBus (
    .clk(clk), .rstN(rstN),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .rdValue(rdValue), .st(st)
  );

  kctl_regs #(.DATA_W(DATA_W), .DIM_W(DIM_W)) uRegs (
    .clk(clk), .rstN(rstN), .st(st),
    .wdata(wdata), .wstrb(wstrb), .rdValue(rdValue),
    .kStart(kStart), .kDone(kDone), .kIdle(kIdle), .kReady(kReady),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgPhase(cfgPhase),
    .irq(irq)
  );

endmodule

// File: tb/sim_kernel_ctl_slave.sv
module sim_kernel_ctl_slave;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0]  awaddr = '0;
  logic        awvalid = 1'b0;
  logic        awready;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        wvalid = 1'b0;
  logic        wready;
  logic [1:0]  bresp;
  logic        bvalid;
  logic        bready = 1'b0;
  logic [5:0]  araddr = '0;
  logic        arvalid = 1'b0;
  logic        arready;
  logic [31:0] rdata;
  logic [1:0]  rresp;
  logic        rvalid;
  logic        rready = 1'b0;
  logic        kStart;
  logic        kDone = 1'b0;
  logic        kIdle = 1'b0;
  logic        kReady = 1'b0;
  logic [15:0] cfgWidth, cfgHeight;
  logic [1:0]  cfgPhase;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  kernel_ctl_slave u0 (
    .clk(clk), .rstN(rstN),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .kStart(kStart), .kDone(kDone), .kIdle(kIdle), .kReady(kReady),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgPhase(cfgPhase),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic        mStart, mDone, mAuto, mGie, mPrevD, mPrevR, mBv, mRv;
  logic [1:0]  mIer, mIsr, mPh;
  logic [15:0] mW, mH;
  logic [31:0] mRd;

  function automatic logic [31:0] modelRead(input logic [5:0] a);
    case ({a[5:2], 2'b00})
      6'h00: return {24'd0, mAuto, 3'd0, kReady, kIdle, mDone, mStart};
      6'h04: return {31'd0, mGie};
      6'h08: return {30'd0, mIer};
      6'h0C: return {30'd0, mIsr};
      6'h10: return {16'd0, mW};
      6'h18: return {16'd0, mH};
      6'h28: return {30'd0, mPh};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic aw, ar;
    logic [5:0] wo;
    if (!rstN) begin
      mStart = 0; mDone = 0; mAuto = 0; mGie = 0; mPrevD = 0; mPrevR = 0;
      mBv = 0; mRv = 0; mIer = 0; mIsr = 0; mPh = 0; mW = 0; mH = 0; mRd = 0;
    end else begin
      aw = awvalid && wvalid && !mBv;
      ar = arvalid && !mRv;
      wo = {awaddr[5:2], 2'b00};
      if (ar) mRd = modelRead(araddr);
      if ((aw && wo == 6'h00 && wstrb[0] && wdata[0]) || (mAuto && kDone)) mStart = 1;
      else if (mStart && kReady) mStart = 0;
      if (kDone) mDone = 1;
      else if (ar && araddr[5:2] == 4'd0) mDone = 0;
      if (aw && wstrb[0]) begin
        if (wo == 6'h00) mAuto = wdata[7];
        if (wo == 6'h04) mGie = wdata[0];
        if (wo == 6'h08) mIer = wdata[1:0];
        if (wo == 6'h28) mPh = wdata[1:0];
        if (wo == 6'h0C) mIsr = mIsr ^ wdata[1:0];
      end
      if (kReady && !mPrevR) mIsr[1] = 1;
      if (kDone && !mPrevD) mIsr[0] = 1;
      mPrevR = kReady;
      mPrevD = kDone;
      if (aw && wo == 6'h10) begin
        if (wstrb[0]) mW[7:0]  = wdata[7:0];
        if (wstrb[1]) mW[15:8] = wdata[15:8];
      end
      if (aw && wo == 6'h18) begin
        if (wstrb[0]) mH[7:0]  = wdata[7:0];
        if (wstrb[1]) mH[15:8] = wdata[15:8];
      end
      if (aw) mBv = 1; else if (bready) mBv = 0;
      if (ar) mRv = 1; else if (rready) mRv = 0;
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rstN && !finished) begin
      chk("R3 kStart", 32'(kStart), 32'(mStart));
      chk("R8 irq", 32'(irq), 32'(mGie && |(mIsr & mIer)));
      chk("R2 cfgWidth", 32'(cfgWidth), 32'(mW));
      chk("R2 cfgHeight", 32'(cfgHeight), 32'(mH));
      chk("R2 cfgPhase", 32'(cfgPhase), 32'(mPh));
      chk("R11 bvalid", 32'(bvalid), 32'(mBv));
      chk("R11 rvalid", 32'(rvalid), 32'(mRv));
      chk("R11 awready", 32'(awready), 32'(awvalid && wvalid && !mBv));
      chk("R11 wready", 32'(wready), 32'(awvalid && wvalid && !mBv));
      chk("R11 arready", 32'(arready), 32'(arvalid && !mRv));
      chk("R10 bresp", 32'(bresp), 32'd0);
      chk("R10 rresp", 32'(rresp), 32'd0);
      if (mRv) chk("R2 rdata", rdata, mRd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic axiWrite(input logic [5:0] a, input logic [31:0] d,
                          input logic [3:0] s, input int hold);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    for (int i = 0; i < hold; i++) begin
      chk("R11 bvalid held", 32'(bvalid), 32'd1);
      @(negedge clk);
    end
    chk("R10 bresp okay", 32'(bresp), 32'd0);
    bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic axiRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    @(negedge clk);
    arvalid = 0;
    d = rdata;
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic pulseDone();
    @(negedge clk); kDone = 1;
    @(negedge clk); kDone = 0;
  endtask

  task automatic pulseReady();
    @(negedge clk); kReady = 1;
    @(negedge clk); kReady = 0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 kStart", 32'(kStart), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cfgWidth", 32'(cfgWidth), 0);
    chk("R1 cfgPhase", 32'(cfgPhase), 0);
    axiRead(6'h00, d); chk("R1 control", d, 0);
    axiRead(6'h0C, d); chk("R1 status", d, 0);

    // R2 map and reserved bits
    axiWrite(6'h10, 32'hFFFF_0780, 4'hF, 0);
    axiWrite(6'h18, 32'h0000_0438, 4'hF, 0);
    axiWrite(6'h28, 32'hFFFF_FFFF, 4'hF, 0);
    axiRead(6'h10, d); chk("R2 width", d, 32'h780);
    axiRead(6'h1A, d); chk("R2 height low bits ignored", d, 32'h438);
    axiRead(6'h28, d); chk("R2 phase", d, 32'h3);
    chk("R2 cfgPhase", 32'(cfgPhase), 3);
    axiWrite(6'h04, 32'hFFFF_FFFF, 4'hF, 0);
    axiRead(6'h04, d); chk("R2 gie", d, 32'h1);
    axiWrite(6'h08, 32'hFFFF_FFFF, 4'hF, 0);
    axiRead(6'h08, d); chk("R2 ier", d, 32'h3);
    axiWrite(6'h04, 32'h0, 4'hF, 0);
    axiWrite(6'h08, 32'h0, 4'hF, 0);

    // R9 byte strobes
    axiWrite(6'h10, 32'h0000_AAAA, 4'h1, 0);
    axiRead(6'h10, d); chk("R9 width lane0", d, 32'h07AA);
    axiWrite(6'h18, 32'h0000_1255, 4'h2, 0);
    axiRead(6'h18, d); chk("R9 height lane1", d, 32'h1238);
    axiWrite(6'h28, 32'h0, 4'h2, 0);
    chk("R9 phase needs lane0", 32'(cfgPhase), 3);

    // R10 unmapped
    axiWrite(6'h14, 32'hFFFF_FFFF, 4'hF, 0);
    axiRead(6'h14, d); chk("R10 unmapped read", d, 0);
    axiRead(6'h3C, d); chk("R10 unmapped read high", d, 0);
    chk("R10 width untouched", 32'(cfgWidth), 32'h07AA);

    // R3 start handshake
    axiWrite(6'h00, 32'h1, 4'h1, 0);
    chk("R3 start set", 32'(kStart), 1);
    axiWrite(6'h00, 32'h0, 4'hF, 0);
    chk("R3 zero write keeps start", 32'(kStart), 1);
    // R5 live idle/ready bits
    @(negedge clk); kIdle = 1;
    axiRead(6'h00, d); chk("R5 idle bit", d, 32'h5);
    @(negedge clk); kIdle = 0;
    pulseReady();
    chk("R3 start cleared by ready", 32'(kStart), 0);

    // R4 done latch, clear on read
    pulseDone();
    axiWrite(6'h00, 32'h0, 4'hF, 0);
    axiRead(6'h00, d); chk("R4 done set", d, 32'h2);
    axiRead(6'h00, d); chk("R4 done cleared by read", d, 32'h0);

    // R7 status edges and toggles
    axiRead(6'h0C, d); chk("R7 both status bits", d, 32'h3);
    axiWrite(6'h0C, 32'h1, 4'h1, 0);
    axiRead(6'h0C, d); chk("R7 toggle bit0", d, 32'h2);
    axiWrite(6'h0C, 32'h2, 4'h1, 0);
    axiRead(6'h0C, d); chk("R7 toggle bit1", d, 32'h0);
    axiWrite(6'h0C, 32'h1, 4'h1, 0);
    axiRead(6'h0C, d); chk("R7 toggle sets", d, 32'h1);
    axiWrite(6'h0C, 32'h1, 4'h1, 0);

    // R8 interrupt combination
    axiWrite(6'h04, 32'h1, 4'h1, 0);
    axiWrite(6'h08, 32'h1, 4'h1, 0);
    chk("R8 no pending", 32'(irq), 0);
    pulseDone();
    chk("R8 done raises irq", 32'(irq), 1);
    axiWrite(6'h0C, 32'h1, 4'h1, 0);
    chk("R8 cleared status drops irq", 32'(irq), 0);
    axiWrite(6'h08, 32'h2, 4'h1, 0);
    pulseReady();
    chk("R8 ready raises irq", 32'(irq), 1);
    axiWrite(6'h04, 32'h0, 4'h1, 0);
    chk("R8 global gate", 32'(irq), 0);

    // R6 auto-restart
    axiWrite(6'h00, 32'h80, 4'h1, 0);
    axiRead(6'h00, d); chk("R6 auto bit with done", d, 32'h82);
    axiRead(6'h00, d); chk("R6 auto bit readback", d, 32'h80);
    chk("R6 no start yet", 32'(kStart), 0);
    pulseDone();
    chk("R6 start re-armed", 32'(kStart), 1);
    pulseReady();
    chk("R6 handshake after rearm", 32'(kStart), 0);

    // R11 response hold
    axiWrite(6'h10, 32'h0000_0100, 4'h3, 3);
    chk("R11 write after hold", 32'(cfgWidth), 32'h0100);
    @(negedge clk);
    araddr = 6'h10; arvalid = 1;
    @(negedge clk);
    arvalid = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R11 rvalid held", 32'(rvalid), 1);
      chk("R11 rdata held", rdata, 32'h0100);
      @(negedge clk);
    end
    rready = 1;
    @(negedge clk);
    rready = 0;
    chk("R11 rvalid dropped", 32'(rvalid), 0);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule